// File: doc/BRIEF.md
# Channel Status Transmit Sequencer

This block feeds the channel-status bit of a digital audio transmitter. The 192 channel-status bits of one block are held by software in six 32-bit words. On every frame the transmit shifter raises a one-cycle advance strobe, and the sequencer answers with the status bit that belongs to that frame. It walks through the six words from the first to the last. It copies each word into an internal shift register when that word is needed, and emits the bits least significant first.

The first word is loaded on the frame that carries the block-start preamble, so bit 0 of the status block always lines up with frame 0 of the audio block. After the last bit of the sixth word the sequencer idles and sends zeros until the next block start. A busy flag tells software when the early words are in use. It rises when the first word is loaded. It falls when the last word is loaded, or at the next frame boundary after the transmitter is switched off. This gives software a safe window to rewrite the words for the next block.

Top module: `cs_tx_seq`

## Requirements
- R1: After a synchronous reset, status_bit and busy are both 0.
- R2: The sequencer runs only while tx_en and cs_en are both 1. A strobe that arrives with either enable at 0 leaves status_bit at 0 and busy at 0, and a block start on such a strobe is ignored.
- R3: A strobe with blk_start set loads word 0 (cs_words[31:0]) and emits its bit 0. This also happens in the middle of a block, which restarts the sequence at word 0.
- R4: Each later strobe emits the next bit, least significant first. Word k occupies cs_words[32k+31:32k], and the words are sent in the order k = 0 to 5, so frame n of a block carries bit n%32 of word n/32.
- R5: busy rises on the strobe that loads word 0.
- R6: busy falls on the strobe that loads word 5, which is frame 160 of the block.
- R7: Once all 192 bits have been sent, later strobes without a block start give status_bit 0 and busy 0.
- R8: When tx_en is cleared, busy holds its value until the next strobe. On that strobe busy and status_bit go to 0, and the sequence is abandoned.
- R9: Each word is sampled when it is loaded. A change to a word that is already in the shifter does not affect the current block.
- R10: status_bit and busy are registered. They change only in the cycle after a strobe and hold steady between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| cs_en | input | 1 | Channel-status insertion enable |
| frame_adv | input | 1 | One-cycle strobe, once per frame |
| blk_start | input | 1 | Current frame carries the block-start preamble (qualified by frame_adv) |
| cs_words | input | 192 | Six status words, word k at bits 32k+31:32k |
| status_bit | output | 1 | Channel-status bit for the current frame |
| busy | output | 1 | Early words in use |

## Verification
Both outputs come from a single register stage. The value for a frame is therefore due in the first cycle after the clock edge that samples frame_adv. The bench raises the strobe at a falling edge and drops it at the next falling edge, then samples at that same point, half a cycle after the update. It holds the inputs quiet for several more cycles and samples again, to confirm that nothing moves between strobes. A reference model in the bench, built from the frame position and a copy of each word taken when the model loads it, gives the expected bit and busy value for every strobe. The shutdown case also checks busy at non-strobe cycles after tx_en falls, to show that the drop waits for the frame boundary.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int unsigned CS_WORDS_DEF  = 6;
  localparam int unsigned CS_WORD_W_DEF = 32;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_LOAD  = 2'd1,
    SH_SHIFT = 2'd2,
    SH_CLEAR = 2'd3
  } sh_op_e;
endpackage

// File: rtl/cs_word_pick.sv
module cs_word_pick #(
  parameter int unsigned NUM_WORDS = 6,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words_i,
  input  logic [IDX_W-1:0]            sel_i,
  output logic [WORD_W-1:0]           word_o
);
  logic [WORD_W-1:0] word_arr [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_split
    assign word_arr[g] = words_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (sel_i == IDX_W'(i)) word_o = word_arr[i];
    end
  end
endmodule

// File: rtl/cs_bit_shifter.sv
module cs_bit_shifter
  import cs_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  sh_op_e            op_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh_q;
  logic              bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      unique case (op_i)
        SH_LOAD: begin
          bit_q <= word_i[0];
          sh_q  <= word_i >> 1;
        end
        SH_SHIFT: begin
          bit_q <= sh_q[0];
          sh_q  <= sh_q >> 1;
        end
        SH_CLEAR: begin
          bit_q <= 1'b0;
          sh_q  <= '0;
        end
        default: ;
      endcase
    end
  end

  assign bit_o = bit_q;

  // R9: a load presents the sampled word's bit 0 on the following cycle
  assert_load_bit0_R9: assert property (@(posedge clk) disable iff (rst)
    (op_i == SH_LOAD) |=> (bit_o == $past(word_i[0])));

  // R7: a clear drives the bit to zero
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == SH_CLEAR) |=> !bit_o);
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 6,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned CNT_W    = $clog2(WORD_W + 1),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en_i,
  input  logic             cs_en_i,
  input  logic             frame_adv_i,
  input  logic             blk_start_i,
  output sh_op_e           op_o,
  output logic [IDX_W-1:0] load_idx_o,
  output logic             busy_o
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             active;
  logic             word_done;

  assign active    = tx_en_i & cs_en_i;
  assign word_done = (cnt_q == CNT_W'(WORD_W));

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    busy_d     = busy_q;
    op_o       = SH_HOLD;
    load_idx_o = '0;
    if (frame_adv_i) begin
      if (!active) begin
        state_d = SEQ_IDLE;
        busy_d  = 1'b0;
        op_o    = SH_CLEAR;
      end else if (blk_start_i) begin
        state_d    = SEQ_RUN;
        idx_d      = '0;
        cnt_d      = CNT_W'(1);
        busy_d     = 1'b1;
        op_o       = SH_LOAD;
        load_idx_o = '0;
      end else if (state_q == SEQ_RUN) begin
        if (!word_done) begin
          cnt_d = cnt_q + CNT_W'(1);
          op_o  = SH_SHIFT;
        end else if (idx_q == LAST_IDX) begin
          state_d = SEQ_IDLE;
          busy_d  = 1'b0;
          op_o    = SH_CLEAR;
        end else begin
          idx_d      = idx_q + IDX_W'(1);
          cnt_d      = CNT_W'(1);
          op_o       = SH_LOAD;
          load_idx_o = idx_q + IDX_W'(1);
          if (idx_q + IDX_W'(1) == LAST_IDX) busy_d = 1'b0;
        end
      end else begin
        op_o = SH_CLEAR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  assign busy_o = busy_q;

  // R5: busy only rises on a strobe that carried the block start
  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(frame_adv_i && blk_start_i && active));

  // R10: busy changes only as a result of a strobe
  assert_busy_steady_R10: assert property (@(posedge clk) disable iff (rst)
    !frame_adv_i |=> $stable(busy_o));

  // R8: a strobe seen with the sequencer disabled leaves busy low
  assert_off_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_adv_i && !active) |=> !busy_o);

  // R6: busy is never held while the last word is in the shifter
  assert_last_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN && idx_q == LAST_IDX) |-> !busy_o);

  // R4: the bit counter never passes one word's width
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_W));
endmodule

// File: rtl/cs_tx_seq.sv
module cs_tx_seq
  import cs_seq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = CS_WORDS_DEF,
  parameter int unsigned WORD_W    = CS_WORD_W_DEF,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tx_en,
  input  logic                        cs_en,
  input  logic                        frame_adv,
  input  logic                        blk_start,
  input  logic [NUM_WORDS*WORD_W-1:0] cs_words,
  output logic                        status_bit,
  output logic                        busy
);
  sh_op_e            sh_op;
  logic [IDX_W-1:0]  load_idx;
  logic [WORD_W-1:0] load_word;

  cs_seq_ctrl #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tx_en_i     (tx_en),
    .cs_en_i     (cs_en),
    .frame_adv_i (frame_adv),
    .blk_start_i (blk_start),
    .op_o        (sh_op),
    .load_idx_o  (load_idx),
    .busy_o      (busy)
  );

  cs_word_pick #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_pick (
    .words_i (cs_words),
    .sel_i   (load_idx),
    .word_o  (load_word)
  );

  cs_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .op_i   (sh_op),
    .word_i (load_word),
    .bit_o  (status_bit)
  );

  // R10: the status bit moves only after a strobe
  assert_bit_steady_R10: assert property (@(posedge clk) disable iff (rst)
    !frame_adv |=> $stable(status_bit));

  // R2: a strobe with the sequencer disabled yields a zero bit
  assert_off_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_adv && !(tx_en && cs_en)) |=> !status_bit);
endmodule

// File: tb/cs_tx_seq_tb.sv
`timescale 1ns/1ps
module cs_tx_seq_tb;
  localparam int NW = 6;
  localparam int WW = 32;
  localparam int NBITS = NW * WW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, cs_en = 1'b0, frame_adv = 1'b0, blk_start = 1'b0;
  logic [NW*WW-1:0] cs_words = '0;
  logic status_bit, busy;

  int n_chk = 0;
  int n_bad = 0;

  logic [WW-1:0] snap [NW];
  int  pos = -1;
  logic e_bit = 1'b0, e_busy = 1'b0;

  always #10 clk = ~clk;

  cs_tx_seq u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cs_en(cs_en),
    .frame_adv(frame_adv), .blk_start(blk_start), .cs_words(cs_words),
    .status_bit(status_bit), .busy(busy)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b (pos %0d)", req, what, act, exp, pos);
    end
  endtask

  task automatic mdl(input logic start);
    if (!(tx_en && cs_en)) begin
      pos = -1; e_bit = 1'b0; e_busy = 1'b0;
    end else if (start) begin
      pos = 0; snap[0] = cs_words[0 +: WW]; e_bit = snap[0][0]; e_busy = 1'b1;
    end else if (pos >= 0 && pos < NBITS - 1) begin
      pos++;
      if (pos % WW == 0) snap[pos/WW] = cs_words[(pos/WW)*WW +: WW];
      e_bit = snap[pos/WW][pos%WW];
      if (pos == (NW - 1) * WW) e_busy = 1'b0;
    end else begin
      pos = -1; e_bit = 1'b0;
    end
  endtask

  task automatic frame(input logic start, input string req, input int gap);
    @(negedge clk);
    frame_adv = 1'b1; blk_start = start;
    @(negedge clk);
    frame_adv = 1'b0; blk_start = 1'b0;
    mdl(start);
    check(req, status_bit, e_bit, "status_bit");
    check(req, busy, e_busy, "busy");
    if (gap > 0) begin
      repeat (gap) @(negedge clk);
      check("R10", status_bit, e_bit, "status_bit held");
      check("R10", busy, e_busy, "busy held");
    end
  endtask

  task automatic load_words(input int seed);
    for (int k = 0; k < NW; k++)
      cs_words[k*WW +: WW] = 32'h9E3779B9 * (k + 1 + seed) ^ {16'(k), 16'(seed)};
  endtask

  task automatic t_reset();
    check("R1", status_bit, 1'b0, "status_bit after reset");
    check("R1", busy, 1'b0, "busy after reset");
  endtask

  task automatic t_full_block();
    tx_en = 1'b1; cs_en = 1'b1;
    load_words(1);
    frame(1'b1, "R3", 0);
    check("R5", busy, 1'b1, "busy on first load");
    for (int f = 1; f < NBITS; f++) begin
      frame(1'b0, (f == 160) ? "R6" : "R4", (f % 37 == 0) ? 3 : 0);
      if (f == 159) check("R6", busy, 1'b1, "busy before last word");
      if (f == 160) check("R6", busy, 1'b0, "busy at last word load");
    end
    for (int f = 0; f < 3; f++) frame(1'b0, "R7", 2);
    frame(1'b1, "R3", 0);
    check("R5", busy, 1'b1, "busy on next block");
  endtask

  task automatic t_restart();
    for (int f = 0; f < 45; f++) frame(1'b0, "R4", 0);
    frame(1'b1, "R3", 0);
    for (int f = 0; f < 40; f++) frame(1'b0, "R4", 0);
  endtask

  task automatic t_sample();
    load_words(2);
    frame(1'b1, "R9", 0);
    for (int f = 0; f < 4; f++) frame(1'b0, "R9", 0);
    cs_words[0 +: WW] = ~cs_words[0 +: WW];
    cs_words[WW +: WW] = 32'hA5C3_0F96;
    for (int f = 5; f < NBITS; f++) frame(1'b0, "R9", 0);
    frame(1'b1, "R9", 0);
    for (int f = 0; f < 10; f++) frame(1'b0, "R9", 0);
  endtask

  task automatic t_shutdown();
    for (int f = 0; f < 20; f++) frame(1'b0, "R4", 0);
    @(negedge clk); tx_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", busy, 1'b1, "busy held until frame end");
    frame(1'b0, "R8", 2);
    @(negedge clk); tx_en = 1'b1;
    for (int f = 0; f < 3; f++) frame(1'b0, "R8", 0);
  endtask

  task automatic t_cs_off();
    cs_en = 1'b0;
    frame(1'b1, "R2", 2);
    for (int f = 0; f < 3; f++) frame(1'b0, "R2", 0);
    tx_en = 1'b0; cs_en = 1'b1;
    frame(1'b1, "R2", 2);
    tx_en = 1'b1;
    frame(1'b1, "R3", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_block();
    t_restart();
    t_sample();
    frame(1'b1, "R3", 0);
    t_shutdown();
    t_cs_off();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule